// File: doc/BRIEF.md
# Video Peripheral Bus Slave Front End

This block is the CPU-facing front end of a video and sound peripheral. It watches a shared processor bus, decides whether the current cycle is meant for this peripheral by combining four chip-select pins of mixed polarity, and turns qualified write cycles into single-cycle, one-hot register write strobes together with a captured copy of the data byte. Only six address bits reach the block. The CPU therefore sees 64 register offsets, and the address bits that are not wired in produce mirrored copies of them. The register file behind the strobes is outside this block.

The data bus is split. The lower six bits are receive-only. The top two bits are bidirectional and return read data from the register file during a selected read. The block also contains the wait-for-sync logic. A write to a dedicated offset pulls the active-low ready output low to stall the CPU. A horizontal-blank-start strobe from the video timing chain releases it again.

Top module: `vbus_front`

## Requirements
- R1: After reset `rdy_n` is 1, every bit of `wr_stb` is 0 and `dbus_oe` is 0.
- R2: The access is selected only when `csel[1]` is 1 and `csel[0]`, `csel[2]` and `csel[3]` are all 0. Bit 1 is active-high and the other three bits are active-low. If any single pin is at its inactive level, the cycle produces no strobe, no bus drive and no stall.
- R3: A cycle is a qualified write when it is selected, `phi2` is 1 and `rw` is 0. On the first clock of a qualified write, `wr_stb` bit number `addr` goes to 1 one clock later, for exactly one clock, however long the write is held.
- R4: The byte on `dbus_in[7:0]` during the first clock of a qualified write appears on `wr_data` together with the strobe.
- R5: A cycle with `rw` equal to 1 (a CPU read) never produces a write strobe.
- R6: During a selected cycle with `phi2` at 1 and `rw` at 1, `dbus_oe` is 1 and `dbus_out` equals `rd_hi` in the same cycle, combinationally. These two bits are data bits 7 and 6. In every other case `dbus_oe` is 0 and `dbus_out` is 0.
- R7: A qualified write to offset `WAIT_OFS` (default 6'h02) drives `rdy_n` to 0 one clock after the first clock of the write, in the same cycle as its strobe.
- R8: While `rdy_n` is 0, a one-clock pulse on `hblank_start` sets `rdy_n` back to 1 on the next clock. A pulse while `rdy_n` is 1 has no effect.
- R9: If a wait-offset write and `hblank_start` arrive on the same clock, the wait write wins and `rdy_n` stays 0 until a later `hblank_start`.
- R10: Writes to any other offset, and reads of `WAIT_OFS`, leave `rdy_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | CPU phase-2 level; accesses are valid while it is 1 |
| csel | input | 4 | Chip-select pins; bit 1 is active-high, bits 0, 2 and 3 are active-low |
| rw | input | 1 | 1 = CPU reads, 0 = CPU writes |
| addr | input | 6 | Register offset |
| dbus_in | input | 8 | Data bus as seen at the pins |
| rd_hi | input | 2 | Read data for bits 7..6 from the register file |
| hblank_start | input | 1 | One-clock strobe at the start of horizontal blank |
| dbus_out | output | 2 | Drive value for data bits 7..6 |
| dbus_oe | output | 1 | Output enable for data bits 7..6 |
| wr_stb | output | 64 | One-hot register write strobes |
| wr_data | output | 8 | Byte captured with the strobe |
| rdy_n | output | 1 | Active-low ready; 0 stalls the CPU |

## Verification
The bus drive on bits 7..6 is combinational. It is therefore checked a fraction of a clock after the inputs change, inside the same cycle. Write strobes, captured data and the ready output are each one register deep. The bench drives inputs on the falling edge, lets one rising edge pass and samples at the following falling edge. It then samples once more one clock later to confirm that the strobe has ended even though the write is still held. The ready release is sampled on the falling edge after the rising edge that sees `hblank_start`.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
    localparam int OFS_W   = 6;
    localparam int NREG    = 1 << OFS_W;
    localparam int DATA_W  = 8;
    localparam int HI_W    = 2;
    localparam int CS_N    = 4;
    // polarity of each select pin: 1 = active-high
    localparam logic [CS_N-1:0] CS_POL = 4'b0010;
    localparam logic [OFS_W-1:0] WAIT_OFS = 6'h02;

    typedef struct packed {
        logic              prev;
        logic [NREG-1:0]   stb;
        logic [DATA_W-1:0] data;
    } dec_st_t;

    typedef struct packed {
        logic stall;
    } sync_st_t;
endpackage

// File: rtl/vbus_csel_qual.sv
module vbus_csel_qual #(
    parameter int               CS_N   = vbus_pkg::CS_N,
    parameter logic [CS_N-1:0]  CS_POL = vbus_pkg::CS_POL
) (
    input  logic [CS_N-1:0] csel_i,
    output logic            sel_o
);
    logic [CS_N-1:0] act;

    for (genvar i = 0; i < CS_N; i++) begin : g_pin
        if (CS_POL[i]) begin : g_hi
            assign act[i] = csel_i[i];
        end else begin : g_lo
            assign act[i] = ~csel_i[i];
        end
    end

    assign sel_o = &act;
endmodule

// File: rtl/vbus_wr_decode.sv
module vbus_wr_decode
    import vbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              phi2_i,
    input  logic              rw_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              fire_o,
    output logic [NREG-1:0]   wr_stb_o,
    output logic [DATA_W-1:0] wr_data_o
);
    dec_st_t st_d, st_q;
    logic    wr_now;

    always_comb begin
        wr_now      = sel_i & phi2_i & ~rw_i;
        fire_o      = wr_now & ~st_q.prev;
        st_d        = st_q;
        st_d.prev   = wr_now;
        st_d.stb    = '0;
        if (fire_o) begin
            st_d.stb  = NREG'(1) << addr_i;
            st_d.data = din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_stb_o  = st_q.stb;
    assign wr_data_o = st_q.data;

    // R3
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o));
    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb_o) |=> !(|wr_stb_o));
    // R5
    stb_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_d.stb) |=> $past(!rw_i && phi2_i && sel_i));
endmodule

// File: rtl/vbus_wsync.sv
module vbus_wsync
    import vbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_wr_i,
    input  logic hblank_i,
    output logic rdy_n_o
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wait_wr_i)     st_d.stall = 1'b1;
        else if (hblank_i) st_d.stall = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy_n_o = ~st_q.stall;

    // R7
    stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_wr_i |=> !rdy_n_o);
    // R8
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank_i && !wait_wr_i) |=> rdy_n_o);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_wr_i && !hblank_i) |=> $stable(rdy_n_o));
endmodule

// File: rtl/vbus_front.sv
module vbus_front
    import vbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [CS_N-1:0]   csel,
    input  logic              rw,
    input  logic [OFS_W-1:0]  addr,
    input  logic [DATA_W-1:0] dbus_in,
    input  logic [HI_W-1:0]   rd_hi,
    input  logic              hblank_start,
    output logic [HI_W-1:0]   dbus_out,
    output logic              dbus_oe,
    output logic [NREG-1:0]   wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              rdy_n
);
    logic sel;
    logic fire;
    logic wait_wr;

    vbus_csel_qual u_csel (
        .csel_i (csel),
        .sel_o  (sel)
    );

    vbus_wr_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .phi2_i    (phi2),
        .rw_i      (rw),
        .addr_i    (addr),
        .din_i     (dbus_in),
        .fire_o    (fire),
        .wr_stb_o  (wr_stb),
        .wr_data_o (wr_data)
    );

    assign wait_wr = fire && (addr == WAIT_OFS);

    vbus_wsync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_wr_i (wait_wr),
        .hblank_i  (hblank_start),
        .rdy_n_o   (rdy_n)
    );

    always_comb begin
        dbus_oe  = sel & phi2 & rw;
        dbus_out = dbus_oe ? rd_hi : '0;
    end

    // R6
    oe_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> (csel == CS_POL) && rw && phi2);
    // R2
    stb_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |-> $past(csel == CS_POL));
endmodule

// File: tb/vbus_front_tb_top.sv
module vbus_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic [3:0]  csel = 4'b1101;
    logic        rw = 1'b1;
    logic [5:0]  addr = '0;
    logic [7:0]  dbus_in = '0;
    logic [1:0]  rd_hi = 2'b10;
    logic        hblank_start = 1'b0;
    logic [1:0]  dbus_out;
    logic        dbus_oe;
    logic [63:0] wr_stb;
    logic [7:0]  wr_data;
    logic        rdy_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vbus_front dut_i (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .csel(csel), .rw(rw),
        .addr(addr), .dbus_in(dbus_in), .rd_hi(rd_hi),
        .hblank_start(hblank_start), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
        .wr_stb(wr_stb), .wr_data(wr_data), .rdy_n(rdy_n)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {csel, rw, addr, data, exp_strobe, exp_oe}
    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {4'b0010, 1'b0, 6'h03, 8'hA5, 1'b1, 1'b0},
        {4'b0010, 1'b0, 6'h3F, 8'h3C, 1'b1, 1'b0},
        {4'b0010, 1'b0, 6'h00, 8'hFF, 1'b1, 1'b0},
        {4'b0010, 1'b1, 6'h05, 8'h00, 1'b0, 1'b1},
        {4'b0011, 1'b0, 6'h04, 8'h11, 1'b0, 1'b0},
        {4'b0000, 1'b0, 6'h04, 8'h11, 1'b0, 1'b0},
        {4'b0110, 1'b0, 6'h04, 8'h11, 1'b0, 1'b0},
        {4'b1010, 1'b0, 6'h04, 8'h11, 1'b0, 1'b0},
        {4'b1010, 1'b1, 6'h04, 8'h00, 1'b0, 1'b0}
    };

    // one access: phi2 held for three clocks, then released
    task automatic access(input logic [3:0] cs, input logic r, input logic [5:0] a,
                          input logic [7:0] d, input logic hb);
        @(negedge clk);
        csel = cs; rw = r; addr = a; dbus_in = d; phi2 = 1'b1; hblank_start = hb;
    endtask

    task automatic idle();
        @(negedge clk);
        phi2 = 1'b0; csel = 4'b1101; rw = 1'b1; hblank_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(rdy_n === 1'b1, "R1 rdy_n", 64'(rdy_n), 1);
        chk(wr_stb === '0, "R1 wr_stb", wr_stb, 0);
        chk(dbus_oe === 1'b0, "R1 dbus_oe", 64'(dbus_oe), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            logic [63:0] exp;
            v = VEC[i];
            access(v[20:17], v[16], v[15:10], v[9:2], 1'b0);
            #1;
            // R6 combinational drive of bits 7..6
            chk(dbus_oe === v[0], "R6 oe", 64'(dbus_oe), 64'(v[0]));
            chk(dbus_out === (v[0] ? rd_hi : 2'b00), "R6 out", 64'(dbus_out),
                64'(v[0] ? rd_hi : 2'b00));
            @(negedge clk);
            exp = v[1] ? (64'd1 << v[15:10]) : 64'd0;
            // R2 R3 R5 strobe one clock later
            chk(wr_stb === exp, "R3 strobe", wr_stb, exp);
            if (v[1]) chk(wr_data === v[9:2], "R4 data", 64'(wr_data), 64'(v[9:2]));
            @(negedge clk);
            chk(wr_stb === '0, "R3 single pulse", wr_stb, 0);
            // R10 other offsets leave ready alone
            chk(rdy_n === 1'b1, "R10 rdy_n", 64'(rdy_n), 1);
            idle();
            chk(dbus_oe === 1'b0, "R6 oe idle", 64'(dbus_oe), 0);
        end

        // R8 hblank while ready has no effect
        @(negedge clk); hblank_start = 1'b1;
        @(negedge clk); hblank_start = 1'b0;
        chk(rdy_n === 1'b1, "R8 no effect", 64'(rdy_n), 1);

        // R7 wait write stalls
        access(4'b0010, 1'b0, 6'h02, 8'h00, 1'b0);
        @(negedge clk);
        chk(rdy_n === 1'b0, "R7 stall", 64'(rdy_n), 0);
        chk(wr_stb === 64'd4, "R7 strobe", wr_stb, 64'd4);
        idle();
        repeat (3) @(negedge clk);
        chk(rdy_n === 1'b0, "R7 held", 64'(rdy_n), 0);
        // R10 read of wait offset and other write keep stall
        access(4'b0010, 1'b1, 6'h02, 8'h00, 1'b0);
        idle();
        access(4'b0010, 1'b0, 6'h09, 8'h00, 1'b0);
        idle();
        chk(rdy_n === 1'b0, "R10 unchanged", 64'(rdy_n), 0);
        // R8 release
        @(negedge clk); hblank_start = 1'b1;
        @(negedge clk); hblank_start = 1'b0;
        chk(rdy_n === 1'b1, "R8 release", 64'(rdy_n), 1);

        // R9 simultaneous wait write and hblank
        access(4'b0010, 1'b0, 6'h02, 8'h00, 1'b1);
        @(negedge clk); hblank_start = 1'b0;
        chk(rdy_n === 1'b0, "R9 write wins", 64'(rdy_n), 0);
        idle();
        chk(rdy_n === 1'b0, "R9 still low", 64'(rdy_n), 0);
        @(negedge clk); hblank_start = 1'b1;
        @(negedge clk); hblank_start = 1'b0;
        chk(rdy_n === 1'b1, "R9 later release", 64'(rdy_n), 1);

        // R2 deselected wait write does not stall
        access(4'b0011, 1'b0, 6'h02, 8'h00, 1'b0);
        @(negedge clk);
        chk(rdy_n === 1'b1, "R2 deselected wait", 64'(rdy_n), 1);
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule